// File: doc/BRIEF.md
# Oversampled AMI Clock Recovery

This block takes the two pulse flags of a T1 receive slicer (one for positive marks, one for negative marks) and turns them into a bit-rate clock enable and a data bit. It runs on a single fast clock at 32 times the line bit rate. Every leading edge of a mark pulls a 0..31 phase counter back into step, and the bit is taken at the middle of the bit period. A mark of either polarity reads as a one and an empty bit period reads as a zero. When two marks in a row have the same polarity, the bit is flagged as a bipolar violation.

A carrier monitor declares the line lost after a long run of empty bit periods. It declares the line back once enough marks return within a fixed window of bits. While the line is lost, the output enable comes from another source. If an auxiliary clock input is seen toggling, each of its rising edges gives one output pulse. If it is not toggling, a free-running divide-by-32 of the fast clock is used. The data output stays low during fallback, so downstream logic always sees a steady bit-rate enable.

Top module: `amirx_recovery`

## Requirements
- R1: Each line bit period gives exactly one `rclk_en_o` pulse while the source is the line. `rdata_o` is 1 when a mark of either polarity (`pos_pulse_i` or `neg_pulse_i` high) began in that period, and 0 when none did.
- R2: The leading edge of every mark re-centres the phase counter. The bit is sampled 16 fast cycles after that edge. With no edges the sample repeats every 32 fast cycles, so marks that start up to 3 fast cycles late within their slot still decode correctly.
- R3: `bpv_o` is 1 together with a one bit when that mark has the same polarity as the previous mark. It is 0 otherwise. The first mark after reset is never a violation.
- R4: `carrier_lost_o` rises after 192 consecutive zero bits. A run of 191 zeros followed by a one does not raise it.
- R5: While lost, `carrier_lost_o` clears at the end of a 192-bit window holding at least 24 ones. A pattern of one mark every 9 bits (at most 22 per window) never clears it. One mark every 8 bits (24 per window) does clear it.
- R6: `aux_clk_i` passes through a two-stage synchroniser. `aux_ok_o` goes high after an edge and falls once 64 fast cycles pass with no edge.
- R7: `src_o` is 0 (line) whenever the carrier is present, 1 (auxiliary) when lost with `aux_ok_o` high, and 2 (local) when lost with the auxiliary clock absent.
- R8: In source 2, `rclk_en_o` pulses every 32 fast cycles. In source 1, it pulses once per rising edge of the auxiliary clock.
- R9: While `src_o` is not 0, `rdata_o` and `bpv_o` are 0.
- R10: During reset, `carrier_lost_o`=1, `aux_ok_o`=0, `src_o`=2, and `rclk_en_o`=`rdata_o`=`bpv_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at 32x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| pos_pulse_i | input | 1 | Slicer flag for a positive mark |
| neg_pulse_i | input | 1 | Slicer flag for a negative mark |
| aux_clk_i | input | 1 | Asynchronous auxiliary bit clock |
| rclk_en_o | output | 1 | One-cycle bit clock enable |
| rdata_o | output | 1 | Recovered bit, valid with the enable |
| bpv_o | output | 1 | Bipolar violation on this bit |
| carrier_lost_o | output | 1 | Receive carrier loss flag |
| aux_ok_o | output | 1 | Auxiliary clock sensed as toggling |
| src_o | output | 2 | Enable source: 0 line, 1 auxiliary, 2 local |

## Verification
Decoding is exercised with a random mark/space stream. Each mark starts 0 to 3 fast cycles late in its slot, and about a tenth of the marks repeat the previous polarity. This separates phase tracking (R2) from plain polarity-blind decoding (R1) and from violation flagging (R3). The carrier monitor is driven with runs of exactly 191 and 192 zeros to pin down the loss threshold. After that, periodic patterns of one mark in 9 and one mark in 8 bits show that the 24-per-192 density rule applies whatever the window alignment. The fallback paths are told apart by the spacing of the enable: 40 cycles while an auxiliary clock with a 40-cycle period runs, and 32 cycles once it has stopped long enough for the 64-cycle timeout.

// File: rtl/amirx_pkg.sv
package amirx_pkg;

    // Source of the output bit clock enable
    typedef enum logic [1:0] {
        SRC_LINE  = 2'd0,
        SRC_AUX   = 2'd1,
        SRC_LOCAL = 2'd2
    } clk_src_e;

    // One decoded bit event from the phase tracker
    typedef struct packed {
        logic strobe;
        logic data;
        logic bpv;
    } bit_evt_t;

    // Priority: line carrier, then sensed auxiliary clock, then local divider
    function automatic clk_src_e pick_src(input logic lost, input logic aux_ok);
        if (!lost) begin
            return SRC_LINE;
        end
        if (aux_ok) begin
            return SRC_AUX;
        end
        return SRC_LOCAL;
    endfunction

endpackage

// File: rtl/amirx_phase.sv
module amirx_phase
    import amirx_pkg::*;
#(
    parameter int OSR = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pos_i,
    input  logic     neg_i,
    output bit_evt_t evt_o
);
    localparam int PW  = $clog2(OSR);
    localparam int MID = OSR / 2;

    logic          pos_r, neg_r, mark_q;
    logic [PW-1:0] phase_q;
    logic          seen_q, bpv_seen_q;
    logic          last_pos_q, pol_valid_q;
    logic          mark_now, edge_w, viol_w, strobe_w;

    assign mark_now = pos_r | neg_r;
    assign edge_w   = mark_now & ~mark_q;
    assign viol_w   = edge_w & pol_valid_q & (pos_r == last_pos_q);
    assign strobe_w = (phase_q == PW'(MID));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_r       <= 1'b0;
            neg_r       <= 1'b0;
            mark_q      <= 1'b0;
            phase_q     <= '0;
            seen_q      <= 1'b0;
            bpv_seen_q  <= 1'b0;
            last_pos_q  <= 1'b0;
            pol_valid_q <= 1'b0;
            evt_o       <= '0;
        end else begin
            pos_r  <= pos_i;
            neg_r  <= neg_i;
            mark_q <= mark_now;

            if (edge_w) begin
                phase_q     <= PW'(1);
                last_pos_q  <= pos_r;
                pol_valid_q <= 1'b1;
            end else if (phase_q == PW'(OSR - 1)) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end

            if (strobe_w) begin
                evt_o.strobe <= 1'b1;
                evt_o.data   <= seen_q | edge_w;
                evt_o.bpv    <= bpv_seen_q | viol_w;
                seen_q       <= 1'b0;
                bpv_seen_q   <= 1'b0;
            end else begin
                evt_o.strobe <= 1'b0;
                seen_q       <= seen_q | edge_w;
                bpv_seen_q   <= bpv_seen_q | viol_w;
            end
        end
    end

    // Checker state: cycles since the previous sample, and whether a mark edge intervened
    logic [PW:0] gap_q;
    logic        fresh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            fresh_q <= 1'b1;
        end else if (strobe_w) begin
            gap_q   <= (PW+1)'(1);
            fresh_q <= edge_w;
        end else begin
            gap_q   <= gap_q + 1'b1;
            fresh_q <= fresh_q | edge_w;
        end
    end

    // R2: with no mark edge in between, samples are exactly one bit period apart
    p_free_run_period_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe_w && !fresh_q && !edge_w) |-> (gap_q == (PW+1)'(OSR)));

    // R3: a violation is only ever reported on a one bit
    p_bpv_on_one_r3: assert property (@(posedge clk) disable iff (rst)
        evt_o.bpv |-> evt_o.data);

endmodule

// File: rtl/amirx_carrier.sv
module amirx_carrier #(
    parameter int ZERO_LIMIT = 192,
    parameter int WIN_BITS   = 192,
    parameter int MIN_ONES   = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic data_i,
    output logic lost_o
);
    localparam int ZW = $clog2(ZERO_LIMIT + 1);
    localparam int WW = $clog2(WIN_BITS);
    localparam int OW = $clog2(WIN_BITS + 1);

    logic [ZW-1:0] zrun_q;
    logic [WW-1:0] wcnt_q;
    logic [OW-1:0] ones_q, ones_next;
    logic          win_end;

    assign ones_next = ones_q + OW'(data_i);
    assign win_end   = (wcnt_q == WW'(WIN_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_o <= 1'b1;
            zrun_q <= '0;
            wcnt_q <= '0;
            ones_q <= '0;
        end else if (strobe_i) begin
            if (data_i) begin
                zrun_q <= '0;
            end else if (zrun_q != ZW'(ZERO_LIMIT)) begin
                zrun_q <= zrun_q + 1'b1;
            end

            if (win_end) begin
                wcnt_q <= '0;
                ones_q <= '0;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
                ones_q <= ones_next;
            end

            if (!data_i && zrun_q == ZW'(ZERO_LIMIT - 1)) begin
                lost_o <= 1'b1;
            end else if (win_end && ones_next >= OW'(MIN_ONES)) begin
                lost_o <= 1'b0;
            end
        end
    end

    // R4: loss is only declared on a sampled zero bit
    p_loss_on_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_o) |-> $past(strobe_i && !data_i));

    // R5: recovery only happens at the close of a density window
    p_clear_at_window_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(lost_o) |-> $past(strobe_i && win_end));

endmodule

// File: rtl/amirx_auxdet.sv
module amirx_auxdet #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic aux_i,
    output logic present_o,
    output logic rise_o
);
    localparam int CW = $clog2(TIMEOUT);

    logic          s1_q, s2_q, s3_q;
    logic [CW-1:0] idle_q;
    logic          edge_w;

    assign edge_w = s2_q ^ s3_q;
    assign rise_o = s2_q & ~s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= 1'b0;
            s2_q      <= 1'b0;
            s3_q      <= 1'b0;
            idle_q    <= '0;
            present_o <= 1'b0;
        end else begin
            s1_q <= aux_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (edge_w) begin
                idle_q    <= '0;
                present_o <= 1'b1;
            end else if (idle_q == CW'(TIMEOUT - 1)) begin
                present_o <= 1'b0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    // R6: presence is never dropped in a cycle that saw an edge
    p_absent_needs_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(present_o) |-> $past(!edge_w));

    // R6: presence only appears after an observed edge
    p_present_after_edge_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(present_o) |-> $past(edge_w));

endmodule

// File: rtl/amirx_recovery.sv
module amirx_recovery
    import amirx_pkg::*;
#(
    parameter int OSR         = 32,
    parameter int ZERO_LIMIT  = 192,
    parameter int WIN_BITS    = 192,
    parameter int MIN_ONES    = 24,
    parameter int AUX_TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pos_pulse_i,
    input  logic       neg_pulse_i,
    input  logic       aux_clk_i,
    output logic       rclk_en_o,
    output logic       rdata_o,
    output logic       bpv_o,
    output logic       carrier_lost_o,
    output logic       aux_ok_o,
    output logic [1:0] src_o
);
    localparam int DW = $clog2(OSR);

    bit_evt_t      evt;
    logic          lost, aux_ok, aux_rise, local_tick;
    logic [DW-1:0] div_q;
    clk_src_e      src_sel;

    amirx_phase #(.OSR(OSR)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .pos_i (pos_pulse_i),
        .neg_i (neg_pulse_i),
        .evt_o (evt)
    );

    amirx_carrier #(
        .ZERO_LIMIT (ZERO_LIMIT),
        .WIN_BITS   (WIN_BITS),
        .MIN_ONES   (MIN_ONES)
    ) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (evt.strobe),
        .data_i   (evt.data),
        .lost_o   (lost)
    );

    amirx_auxdet #(.TIMEOUT(AUX_TIMEOUT)) u_auxdet (
        .clk       (clk),
        .rst       (rst),
        .aux_i     (aux_clk_i),
        .present_o (aux_ok),
        .rise_o    (aux_rise)
    );

    // Free-running local divider down to the nominal bit rate
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
    assign local_tick = (div_q == DW'(OSR - 1));

    assign src_sel = pick_src(lost, aux_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            rclk_en_o      <= 1'b0;
            rdata_o        <= 1'b0;
            bpv_o          <= 1'b0;
            carrier_lost_o <= 1'b1;
            aux_ok_o       <= 1'b0;
            src_o          <= SRC_LOCAL;
        end else begin
            carrier_lost_o <= lost;
            aux_ok_o       <= aux_ok;
            src_o          <= src_sel;
            case (src_sel)
                SRC_LINE: begin
                    rclk_en_o <= evt.strobe;
                    if (evt.strobe) begin
                        rdata_o <= evt.data;
                        bpv_o   <= evt.bpv;
                    end
                end
                SRC_AUX: begin
                    rclk_en_o <= aux_rise;
                    rdata_o   <= 1'b0;
                    bpv_o     <= 1'b0;
                end
                default: begin
                    rclk_en_o <= local_tick;
                    rdata_o   <= 1'b0;
                    bpv_o     <= 1'b0;
                end
            endcase
        end
    end

    // R7: the line only drives the clock while carrier is present
    p_line_needs_carrier_r7: assert property (@(posedge clk) disable iff (rst)
        (src_o == SRC_LINE) |-> !carrier_lost_o);

    // R7: with carrier lost the choice follows auxiliary presence
    p_fallback_choice_r7: assert property (@(posedge clk) disable iff (rst)
        carrier_lost_o |-> (src_o == (aux_ok_o ? SRC_AUX : SRC_LOCAL)));

    // R9: fallback sources carry no data and no violations
    p_fallback_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (src_o != SRC_LINE) |-> (!rdata_o && !bpv_o));

endmodule

// File: tb/amirx_recovery_bench.sv
`timescale 1ns/1ps
module amirx_recovery_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pos_i = 1'b0, neg_i = 1'b0, aux_i = 1'b0;
    logic       rclk_en, rdata, bpv, lost, aux_ok;
    logic [1:0] src;

    always #4 clk = ~clk;

    amirx_recovery u_amirx_recovery (
        .clk            (clk),
        .rst            (rst),
        .pos_pulse_i    (pos_i),
        .neg_pulse_i    (neg_i),
        .aux_clk_i      (aux_i),
        .rclk_en_o      (rclk_en),
        .rdata_o        (rdata),
        .bpv_o          (bpv),
        .carrier_lost_o (lost),
        .aux_ok_o       (aux_ok),
        .src_o          (src)
    );

    int checks = 0, errors = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor, sampled on the falling edge
    bit capture = 0, have_last = 0, saw_loss = 0, saw_clear = 0;
    int ncap = 0, last_en = 0, gmin = 1000, gmax = 0, fallback_bad = 0;
    bit cap_d[512];
    bit cap_b[512];

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rclk_en) begin
                if (have_last) begin
                    if (cyc - last_en < gmin) gmin = cyc - last_en;
                    if (cyc - last_en > gmax) gmax = cyc - last_en;
                end
                have_last = 1;
                last_en   = cyc;
                if (capture && src == 2'd0 && ncap < 512) begin
                    cap_d[ncap] = rdata;
                    cap_b[ncap] = bpv;
                    ncap++;
                end
            end
            if (src != 2'd0 && (rdata || bpv)) fallback_bad++;
            if (lost) saw_loss = 1;
            else saw_clear = 1;
        end
    end

    // Auxiliary clock generator, period 40 fast cycles
    bit aux_run = 0;
    int last_tog = 0;
    initial begin
        forever begin
            repeat (20) @(negedge clk);
            if (aux_run) begin
                aux_i    = ~aux_i;
                last_tog = cyc;
            end
        end
    end

    // Line stimulus
    bit b_last_pos = 0, b_pol_valid = 0;

    function automatic bit viol_expected(input bit pol, input bit lastp, input bit valid);
        return valid && (pol == lastp);
    endfunction

    task automatic send_slot(input bit mark, input bit pos, input int jit);
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            pos_i = mark && pos && (c >= jit) && (c < jit + 16);
            neg_i = mark && !pos && (c >= jit) && (c < jit + 16);
        end
    endtask

    task automatic send_one(input bit viol, input int jit, output bit expv);
        bit pol;
        pol = viol ? b_last_pos : !b_last_pos;
        expv = viol_expected(pol, b_last_pos, b_pol_valid);
        b_last_pos  = pol;
        b_pol_valid = 1;
        send_slot(1'b1, pol, jit);
    endtask

    task automatic send_bit(input bit d);
        bit dummy;
        if (d) send_one(1'b0, 0, dummy);
        else send_slot(1'b0, 1'b0, 0);
    endtask

    task automatic measure(input int win, input int expg, input string req);
        have_last = 0; gmin = 1000; gmax = 0;
        repeat (win) @(negedge clk);
        chk(gmin == expg, req, "min enable gap", gmin, expg);
        chk(gmax == expg, req, "max enable gap", gmax, expg);
    endtask

    localparam int NRND = 300;
    bit exp_d[NRND];
    bit exp_b[NRND];

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 180000, 0);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (6) @(negedge clk);
        // R10: reset state
        chk(lost == 1'b1, "R10", "carrier_lost in reset", lost, 1);
        chk(aux_ok == 1'b0, "R10", "aux_ok in reset", aux_ok, 0);
        chk(src == 2'd2, "R10", "src in reset", src, 2);
        chk(!rclk_en && !rdata && !bpv, "R10", "en/data/bpv in reset",
            {rclk_en, rdata, bpv}, 0);
        rst = 1'b0;

        // R8: local divider while lost with no auxiliary clock
        repeat (40) @(negedge clk);
        chk(src == 2'd2, "R7", "src with no aux", src, 2);
        measure(400, 32, "R8");

        // R6/R8: auxiliary clock takes over
        aux_run = 1;
        repeat (100) @(negedge clk);
        chk(aux_ok == 1'b1, "R6", "aux_ok while toggling", aux_ok, 1);
        chk(src == 2'd1, "R7", "src with aux", src, 1);
        measure(400, 40, "R8");

        // R6: timeout after the auxiliary clock stops
        aux_run = 0;
        repeat (2) @(negedge clk);
        while (cyc < last_tog + 50) @(negedge clk);
        chk(aux_ok == 1'b1, "R6", "aux_ok 50 cycles after last edge", aux_ok, 1);
        while (cyc < last_tog + 80) @(negedge clk);
        chk(aux_ok == 1'b0, "R6", "aux_ok 80 cycles after last edge", aux_ok, 0);
        chk(src == 2'd2, "R7", "src after aux stops", src, 2);

        // R5: acquire with all-ones AMI
        for (int i = 0; i < 400; i++) send_bit(1'b1);
        chk(lost == 1'b0, "R5", "carrier after all ones", lost, 0);
        chk(src == 2'd0, "R7", "src with carrier", src, 0);

        // R1/R2/R3: directed start, then random marks with late starts
        ncap = 0;
        capture = 1;
        for (int i = 0; i < NRND; i++) begin
            bit d, v, e;
            int jit;
            if (i < 4) begin
                d = (i != 2);
                v = (i == 1);
            end else begin
                d = 1'($urandom_range(0, 1));
                v = d && ($urandom_range(0, 9) == 0);
            end
            jit = $urandom_range(0, 3);
            e = 1'b0;
            if (d) send_one(v, jit, e);
            else send_slot(1'b0, 1'b0, 0);
            exp_d[i] = d;
            exp_b[i] = e;
        end
        repeat (10) @(negedge clk);
        capture = 0;
        chk(ncap == NRND, "R1", "bit enables for stream", ncap, NRND);
        for (int i = 0; i < NRND && i < ncap; i++) begin
            chk(cap_d[i] == exp_d[i], "R2", $sformatf("data bit %0d", i),
                cap_d[i], exp_d[i]);
            chk(cap_b[i] == exp_b[i], "R3", $sformatf("violation bit %0d", i),
                cap_b[i], exp_b[i]);
        end

        // R4: 191 zeros do not lose carrier, 192 do
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        saw_loss = 0;
        for (int i = 0; i < 191; i++) send_bit(1'b0);
        send_bit(1'b1);
        chk(!saw_loss, "R4", "loss after 191 zeros", saw_loss, 0);
        for (int i = 0; i < 191; i++) send_bit(1'b0);
        chk(lost == 1'b0, "R4", "loss after 191 of second run", lost, 0);
        send_bit(1'b0);
        chk(lost == 1'b1, "R4", "loss after 192 zeros", lost, 1);
        chk(src == 2'd2, "R7", "src after loss", src, 2);

        // R5: density rule
        saw_clear = 0;
        for (int i = 0; i < 576; i++) send_bit(i % 9 == 0);
        chk(!saw_clear, "R5", "clear with one in nine", saw_clear, 0);
        for (int i = 0; i < 600; i++) send_bit(i % 8 == 0);
        chk(lost == 1'b0, "R5", "clear with one in eight", lost, 0);
        chk(src == 2'd0, "R7", "src after recovery", src, 0);

        // R9: no data or violations seen while in fallback
        chk(fallback_bad == 0, "R9", "fallback data/bpv cycles", fallback_bad, 0);

        summary();
        $finish;
    end
endmodule